// File: doc/BRIEF.md
# Sensor Measurement Sequencer

This block runs the measurement of an on-chip transducer through an ADC that other blocks also use. Software picks a transducer, an ADC input channel and a settling time, then sets the enable bit. The block powers the chosen transducer and lets it settle for a programmable number of clocks. It then sends a one-clock trigger to the ADC and waits for the ADC's conversion-complete strobe. It latches the converted value and raises a completion flag, which can drive an interrupt.

There are three sub-modes. In single automatic mode, one measurement is taken, the enable bit clears itself, and the transducer is powered down. A hidden lockout interval then follows, during which a new enable is refused. In direct mode, the transducer stays powered and each conversion starts when software writes the trigger address. In low-power repeat mode, the transducer stays powered and a programmable period timer triggers conversions again and again until software clears the enable bit. The analog front end and the ADC are outside the block and appear only as handshake ports.

Top module: `smseq_top`

## Requirements
- R1: After reset, every register reads zero, no transducer power line is high, and irq is low.
- R2: While a measurement is active, exactly one power line is high. Its index is the transducer field of the select register (bit 2; address 1). `adc_chan` equals the ADC field (bits 1:0) of that register.
- R3: The ADC trigger is a single-clock pulse. In automatic mode it comes after the power line has been high for exactly SETTLE+1 clocks, where SETTLE is register address 5.
- R4: When `adc_done` arrives while a conversion is awaited, the block latches `adc_result`. Bits 7:0 go to address 3 and bits 9:8 to address 4. The done flag (address 2, bit 0) is set. `irq` equals the done flag ANDed with the interrupt enable (control bit 0).
- R5: Only a read of address 3 clears the done flag. Reads of address 4 or address 2 leave it set.
- R6: Automatic mode is encoded as 0 in control bits 2:1. In this mode, the enable bit (control bit 4) clears itself at capture and transducer power drops. A lockout of LOCK+1 clocks follows, where LOCK is address 6. A write that sets the enable bit during the lockout is ignored: the bit reads 0 and power stays off.
- R7: Control bit 7 reads 0 in automatic mode. In direct and repeat modes it mirrors the done flag.
- R8: Direct mode is encoded as 1. After settling, the transducer stays powered and no conversion starts by itself. Each write to address 8 while waiting for a trigger produces exactly one trigger. Writes to address 8 at any other time are ignored.
- R9: Repeat mode is encoded as 2. After each capture, the block stays powered and triggers again PERIOD+1 clocks later, where PERIOD is address 7.
- R10: Clearing the enable bit in any active state removes transducer power within two clocks. It also stops all further triggers.
- R11: While a cycle is running, writing the enable bit as 1 is ignored and the bit still reads 1. Writes to the mode and select fields are also ignored while the cycle runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 3) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| xdcr_pwr | output | NXDCR | One-hot transducer power enables |
| adc_chan | output | clog2(NADC) | ADC input channel select |
| adc_trig | output | 1 | One-clock conversion start |
| adc_done | input | 1 | Conversion-complete strobe from the ADC |
| adc_result | input | RES_W | Converted value, valid with `adc_done` |
| irq | output | 1 | Completion interrupt |

## Verification
A sequencer stuck in a powered state would show up as a power line that is still high two clocks after the enable bit drops. A broken lockout would let power return immediately after a refused write. A wrong count in the shared timer moves the trigger edge by whole clocks. The bench therefore measures the distance between the power edge and the trigger, and between successive triggers, exactly and not as a range. A lost or stale capture appears at the first read of the result, because a scoreboard holds every value the ADC model returned.

// File: rtl/smseq_pkg.sv
package smseq_pkg;

    typedef enum logic [1:0] {
        MODE_AUTO   = 2'd0,
        MODE_DIRECT = 2'd1,
        MODE_LOWPWR = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_TRIG,
        ST_WAIT,
        ST_HOLD,
        ST_PERIOD,
        ST_LOCK
    } state_e;

    typedef struct packed {
        state_e st;
    } fsm_t;

    localparam logic [3:0] ADDR_CTRL   = 4'd0;
    localparam logic [3:0] ADDR_SEL    = 4'd1;
    localparam logic [3:0] ADDR_STAT   = 4'd2;
    localparam logic [3:0] ADDR_RESLO  = 4'd3;
    localparam logic [3:0] ADDR_RESHI  = 4'd4;
    localparam logic [3:0] ADDR_SETTLE = 4'd5;
    localparam logic [3:0] ADDR_LOCK   = 4'd6;
    localparam logic [3:0] ADDR_PERIOD = 4'd7;
    localparam logic [3:0] ADDR_TRIG   = 4'd8;

    localparam int CTRL_IRQEN_BIT = 0;
    localparam int CTRL_EN_BIT    = 4;
    localparam int CTRL_FLAG_BIT  = 7;

endpackage

// File: rtl/smseq_counter.sv
module smseq_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R3: the timer must saturate at zero, never wrap into a long wait
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && (cnt_q == '0)) |=> (cnt_q == '0));

endmodule

// File: rtl/smseq_fsm.sv
module smseq_fsm
    import smseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  mode_e            mode,
    input  logic             trig_req,
    input  logic             adc_done,
    input  logic [CNT_W-1:0] settle_cnt,
    input  logic [CNT_W-1:0] lock_cnt,
    input  logic [CNT_W-1:0] period_cnt,
    output logic             powered,
    output logic             adc_trig,
    output logic             capture,
    output logic             auto_clear,
    output logic             idle
);

    fsm_t             cur_q, nxt_d;
    logic             t_load, t_dec, t_zero;
    logic [CNT_W-1:0] t_val;

    smseq_counter #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .dec      (t_dec),
        .zero     (t_zero)
    );

    always_comb begin
        nxt_d      = cur_q;
        t_load     = 1'b0;
        t_val      = '0;
        t_dec      = 1'b0;
        capture    = 1'b0;
        auto_clear = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (en) begin
                    nxt_d.st = ST_SETTLE;
                    t_load   = 1'b1;
                    t_val    = settle_cnt;
                end
            end
            ST_SETTLE: begin
                if (!en) begin
                    nxt_d.st = ST_LOCK;
                    t_load   = 1'b1;
                    t_val    = lock_cnt;
                end else if (t_zero) begin
                    nxt_d.st = (mode == MODE_DIRECT) ? ST_HOLD : ST_TRIG;
                end else begin
                    t_dec = 1'b1;
                end
            end
            ST_TRIG: begin
                if (!en) begin
                    nxt_d.st = ST_LOCK;
                    t_load   = 1'b1;
                    t_val    = lock_cnt;
                end else begin
                    nxt_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!en) begin
                    nxt_d.st = ST_LOCK;
                    t_load   = 1'b1;
                    t_val    = lock_cnt;
                end else if (adc_done) begin
                    capture = 1'b1;
                    if (mode == MODE_DIRECT) begin
                        nxt_d.st = ST_HOLD;
                    end else if (mode == MODE_LOWPWR) begin
                        nxt_d.st = ST_PERIOD;
                        t_load   = 1'b1;
                        t_val    = period_cnt;
                    end else begin
                        nxt_d.st   = ST_LOCK;
                        t_load     = 1'b1;
                        t_val      = lock_cnt;
                        auto_clear = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (!en) begin
                    nxt_d.st = ST_LOCK;
                    t_load   = 1'b1;
                    t_val    = lock_cnt;
                end else if (trig_req) begin
                    nxt_d.st = ST_TRIG;
                end
            end
            ST_PERIOD: begin
                if (!en) begin
                    nxt_d.st = ST_LOCK;
                    t_load   = 1'b1;
                    t_val    = lock_cnt;
                end else if (t_zero) begin
                    nxt_d.st = ST_TRIG;
                end else begin
                    t_dec = 1'b1;
                end
            end
            ST_LOCK: begin
                if (t_zero) nxt_d.st = ST_IDLE;
                else        t_dec    = 1'b1;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q.st <= ST_IDLE;
        else        cur_q    <= nxt_d;
    end

    assign powered  = (cur_q.st == ST_SETTLE) || (cur_q.st == ST_TRIG) ||
                      (cur_q.st == ST_WAIT)   || (cur_q.st == ST_HOLD) ||
                      (cur_q.st == ST_PERIOD);
    assign adc_trig = (cur_q.st == ST_TRIG);
    assign idle     = (cur_q.st == ST_IDLE);

    // R6: the register file must never hold the enable bit during the lockout
    assert_lock_no_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_LOCK) |-> !en);

    // R3: a trigger lasts one clock
    assert_trig_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |=> !adc_trig);

    // R4: a trigger is always followed by waiting for the result (or an abort)
    assert_trig_then_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |=> ((cur_q.st == ST_WAIT) || (cur_q.st == ST_LOCK)));

endmodule

// File: rtl/smseq_top.sv
module smseq_top
    import smseq_pkg::*;
#(
    parameter int NXDCR = 2,
    parameter int NADC  = 4,
    parameter int RES_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [3:0]              bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    output logic [NXDCR-1:0]        xdcr_pwr,
    output logic [((NADC > 1) ? $clog2(NADC) : 1)-1:0] adc_chan,
    output logic                    adc_trig,
    input  logic                    adc_done,
    input  logic [RES_W-1:0]        adc_result,
    output logic                    irq
);

    localparam int DW   = 8;
    localparam int AS_W = (NADC > 1) ? $clog2(NADC) : 1;
    localparam int XS_W = (NXDCR > 1) ? $clog2(NXDCR) : 1;
    localparam int HI_W = RES_W - DW;

    typedef struct packed {
        logic             irq_en;
        mode_e            mode;
        logic             en;
        logic             done;
        logic [AS_W-1:0]  adc_sel;
        logic [XS_W-1:0]  xs_sel;
        logic [RES_W-1:0] result;
        logic [DW-1:0]    settle;
        logic [DW-1:0]    lock;
        logic [DW-1:0]    period;
    } regs_t;

    regs_t r_d, r_q;
    logic  powered, capture, auto_clear, idle, trig_req, cfg_open, rd_lo;

    smseq_fsm #(.CNT_W(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (r_q.en),
        .mode       (r_q.mode),
        .trig_req   (trig_req),
        .adc_done   (adc_done),
        .settle_cnt (r_q.settle),
        .lock_cnt   (r_q.lock),
        .period_cnt (r_q.period),
        .powered    (powered),
        .adc_trig   (adc_trig),
        .capture    (capture),
        .auto_clear (auto_clear),
        .idle       (idle)
    );

    assign trig_req = bus_wr && (bus_addr == ADDR_TRIG);
    assign rd_lo    = bus_rd && (bus_addr == ADDR_RESLO);
    assign cfg_open = idle && !r_q.en;

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            unique case (bus_addr)
                ADDR_CTRL: begin
                    r_d.irq_en = bus_wdata[CTRL_IRQEN_BIT];
                    if (cfg_open) r_d.mode = mode_e'(bus_wdata[2:1]);
                    if (!bus_wdata[CTRL_EN_BIT]) r_d.en = 1'b0;
                    else if (cfg_open)           r_d.en = 1'b1;
                end
                ADDR_SEL: begin
                    if (cfg_open) begin
                        r_d.adc_sel = bus_wdata[AS_W-1:0];
                        r_d.xs_sel  = bus_wdata[AS_W +: XS_W];
                    end
                end
                ADDR_SETTLE: r_d.settle = bus_wdata;
                ADDR_LOCK:   r_d.lock   = bus_wdata;
                ADDR_PERIOD: r_d.period = bus_wdata;
                default: ;
            endcase
        end
        if (auto_clear) r_d.en = 1'b0;
        if (rd_lo)      r_d.done = 1'b0;
        if (capture) begin
            r_d.done   = 1'b1;
            r_d.result = adc_result;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL:   bus_rdata = {(r_q.done && (r_q.mode != MODE_AUTO)), 2'b00,
                                      r_q.en, 1'b0, r_q.mode, r_q.irq_en};
            ADDR_SEL:    bus_rdata = DW'({r_q.xs_sel, r_q.adc_sel});
            ADDR_STAT:   bus_rdata = DW'(r_q.done);
            ADDR_RESLO:  bus_rdata = r_q.result[DW-1:0];
            ADDR_RESHI:  bus_rdata = DW'(r_q.result[DW +: HI_W]);
            ADDR_SETTLE: bus_rdata = r_q.settle;
            ADDR_LOCK:   bus_rdata = r_q.lock;
            ADDR_PERIOD: bus_rdata = r_q.period;
            default:     bus_rdata = '0;
        endcase
    end

    for (genvar g = 0; g < NXDCR; g++) begin : g_pwr
        assign xdcr_pwr[g] = powered && (r_q.xs_sel == XS_W'(g));
    end

    assign adc_chan = r_q.adc_sel;
    assign irq      = r_q.done && r_q.irq_en;

    // R10: power is gone no later than two clocks after the enable bit falls
    assert_pwr_off_after_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.en) |=> ##1 (xdcr_pwr == '0));

    // R5: a low-byte read with no new capture leaves the flag clear
    assert_done_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !capture) |=> !r_q.done);

    // R2: never more than one transducer powered
    assert_pwr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xdcr_pwr));

endmodule

// File: tb/smseq_top_test.sv
module smseq_top_test;

    localparam int S1      = 5;
    localparam int S2      = 9;
    localparam int L       = 20;
    localparam int P       = 4;
    localparam int ADC_LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [1:0] xdcr_pwr, adc_chan;
    logic       adc_trig, adc_done, irq;
    logic [9:0] adc_result;

    int errs = 0, checks = 0;
    int cyc = 0, pre_cnt = 0, last_pre = 0, trig_count = 0, last_trig = 0, prev_trig = 0;
    logic [9:0] exp_q[$];
    logic [9:0] next_val = 10'h2A5;

    always #5 clk = ~clk;

    smseq_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xdcr_pwr(xdcr_pwr), .adc_chan(adc_chan), .adc_trig(adc_trig),
        .adc_done(adc_done), .adc_result(adc_result), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // ADC model: answers each trigger and records the value it returns
    initial begin
        adc_done = 1'b0;
        adc_result = '0;
        forever begin
            @(negedge clk);
            if (adc_trig) begin
                repeat (ADC_LAT) @(negedge clk);
                adc_result = next_val;
                adc_done   = 1'b1;
                exp_q.push_back(next_val);
                next_val   = next_val * 10'd3 + 10'd7;
                @(negedge clk);
                adc_done   = 1'b0;
            end
        end
    end

    // Monitor: powered time before a trigger, trigger count and spacing
    always @(negedge clk) begin
        cyc++;
        if (xdcr_pwr == '0)  pre_cnt = 0;
        else if (!adc_trig)  pre_cnt++;
        if (adc_trig) begin
            trig_count++;
            last_pre  = pre_cnt;
            prev_trig = last_trig;
            last_trig = cyc;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_trig();
        int n = 0;
        do begin @(negedge clk); #1; n++; end while (!adc_trig && n < 2000);
    endtask

    task automatic wait_irq();
        int n = 0;
        do begin @(negedge clk); #1; n++; end while (!irq && n < 2000);
    endtask

    task automatic wait_done();
        int n = 0;
        do begin @(negedge clk); #1; n++; end while (!adc_done && n < 2000);
    endtask

    // Scoreboard pop: compares the result register pair with the oldest ADC value
    task automatic check_result(input string tag);
        logic [7:0] hi, lo;
        logic [9:0] e;
        rd(4'd4, hi);
        rd(4'd3, lo);
        if (exp_q.size() == 0) begin
            checks++; errs++;
            $display("FAIL %s: actual=%0h expected=queued value", tag, {hi[1:0], lo});
        end else begin
            e = exp_q.pop_front();
            chk(tag, {hi[1:0], lo}, e);
        end
    endtask

    initial begin
        logic [7:0] v;
        int tc0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(4'd2, v); chk("R1 stat", v, 8'h00);
        rd(4'd5, v); chk("R1 settle", v, 8'h00);
        chk("R1 pwr", xdcr_pwr, 2'b00);
        chk("R1 irq", irq, 1'b0);

        wr(4'd5, S1); wr(4'd6, L); wr(4'd7, P);

        // Automatic run, interrupt enabled, transducer 1, ADC channel 2
        wr(4'd1, 8'h06);
        wr(4'd0, 8'h11);
        wr(4'd0, 8'h13);                       // R11 re-enable + mode change while running
        rd(4'd0, v); chk("R11 ctrl while running", v, 8'h11);
        wait_trig();
        chk("R3 settle length", last_pre, S1 + 1);
        chk("R2 power line", xdcr_pwr, 2'b10);
        chk("R2 adc channel", adc_chan, 2'd2);
        @(negedge clk); #1 chk("R3 single pulse", adc_trig, 1'b0);
        wait_irq();
        chk("R6 power off after capture", xdcr_pwr, 2'b00);
        rd(4'd0, v); chk("R6 R7 ctrl after capture", v, 8'h01);
        wr(4'd0, 8'h11);                       // refused during lockout
        rd(4'd0, v); chk("R6 enable ignored in lockout", v, 8'h01);
        chk("R6 power stays off", xdcr_pwr, 2'b00);
        rd(4'd2, v); chk("R4 done flag", v, 8'h01);
        rd(4'd4, v);
        rd(4'd2, v); chk("R5 flag kept after high read", v, 8'h01);
        chk("R4 irq raised", irq, 1'b1);
        rd(4'd3, v);
        if (exp_q.size() > 0) chk("R4 low byte", v, {24'h0, exp_q[0][7:0]});
        check_result("R4 result pair");
        rd(4'd2, v); chk("R5 flag cleared by low read", v, 8'h00);
        chk("R5 irq dropped", irq, 1'b0);
        repeat (L + 4) @(negedge clk);
        chk("R6 refused write had no effect", xdcr_pwr, 2'b00);

        // Second automatic run, longer settle, interrupt masked
        wr(4'd5, S2);
        wr(4'd0, 8'h10);
        wait_trig();
        chk("R3 settle length 2", last_pre, S2 + 1);
        wait_done();
        repeat (2) @(negedge clk);
        rd(4'd2, v); chk("R4 done with irq masked", v, 8'h01);
        chk("R4 irq masked", irq, 1'b0);
        rd(4'd0, v); chk("R6 enable self-cleared", v, 8'h00);
        check_result("R4 result pair 2");

        // Direct mode, transducer 0, ADC channel 1
        repeat (L + 4) @(negedge clk);
        wr(4'd1, 8'h01);
        tc0 = trig_count;
        wr(4'd0, 8'h13);
        repeat (S2 + 8) @(negedge clk);
        #1;
        chk("R8 no self trigger", trig_count, tc0);
        chk("R8 held powered", xdcr_pwr, 2'b01);
        chk("R2 adc channel direct", adc_chan, 2'd1);
        wr(4'd8, 8'h00);
        wait_irq();
        chk("R8 one trigger per write", trig_count, tc0 + 1);
        rd(4'd0, v); chk("R7 flag mirrors done", v, 8'h93);
        chk("R8 stays powered", xdcr_pwr, 2'b01);
        check_result("R4 direct result");
        rd(4'd0, v); chk("R7 flag cleared", v, 8'h13);
        wr(4'd8, 8'h00);
        wait_irq();
        chk("R8 second trigger", trig_count, tc0 + 2);
        check_result("R4 direct result 2");
        wr(4'd0, 8'h01);
        repeat (2) @(negedge clk);
        #1 chk("R10 direct power off", xdcr_pwr, 2'b00);
        tc0 = trig_count;
        wr(4'd8, 8'h00);
        repeat (8) @(negedge clk);
        #1 chk("R8 trigger ignored when not waiting", trig_count, tc0);
        rd(4'd0, v); chk("R11 mode kept while active", v, 8'h03);

        // Repeat mode
        repeat (L + 4) @(negedge clk);
        wr(4'd0, 8'h14);
        wait_trig(); wait_trig(); wait_trig();
        chk("R9 repeat spacing", last_trig - prev_trig, P + ADC_LAT + 2);
        chk("R9 powered between", xdcr_pwr, 2'b01);
        wait_done();
        @(negedge clk);
        wr(4'd0, 8'h04);
        repeat (3) @(negedge clk);
        #1 chk("R10 repeat power off", xdcr_pwr, 2'b00);
        tc0 = trig_count;
        repeat (30) @(negedge clk);
        #1 chk("R10 repetition stopped", trig_count, tc0);
        rd(4'd3, v);
        if (exp_q.size() > 0) chk("R9 last capture", v, {24'h0, exp_q[exp_q.size()-1][7:0]});
        exp_q.delete();

        report();
    end

endmodule